// File: doc/BRIEF.md
# Banked Interrupt Controller CPU Interface

This block is the per-processor front end of an interrupt controller. It keeps, for each attached processor, a banked copy of three writable registers: a control word, a priority mask and a binary point. It also keeps a running priority. A single register port reaches every bank, and a processor index input picks the bank for each access. An external arbiter supplies, for each processor, the best pending interrupt: a valid flag, an ID, a priority, a source processor number and an already-active flag. A distributor-wide enable is also an input.

A processor interface counts as enabled only when group-0 enable (control bit 0) or group-1 enable (control bit 1) is set. The control word is stored and read back in full, so flags such as the fast-interrupt flag (control bit 3) are kept but do not enable anything. A read of the acknowledge register returns the pending ID with its source processor, or the spurious ID 1023. A successful acknowledge loads the running priority. Each processor gets its own interrupt request line. The line is re-evaluated on every clock, so it reflects any register write one cycle after that write lands.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, every bank reads control 0, priority mask 0xFF, running priority 0xFF and binary point BPR_RST (default 2), and every interrupt line is low.
- R2: Register offsets are control 0, priority mask 1, binary point 2, acknowledge 3 and running priority 4. A write to offset 0 stores the full 32-bit word, and a read returns that word unchanged.
- R3: A bank is enabled if and only if control bit 0 or bit 1 is set. Any other control value, including bit 3 alone or all other bits set, yields spurious acknowledges and a low interrupt line.
- R4: An acknowledge read with the global enable high, the bank enabled and a valid pending interrupt returns the ID in bits 9:0 and the source processor in bits 12:10, with all other bits zero.
- R5: An acknowledge read returns 1023 when the global enable is low, when the bank is disabled, or when nothing is pending.
- R6: One clock after the conditions hold, a processor's interrupt line is high exactly when the global enable is high, the bank is enabled, the pending interrupt is valid and not active, and its priority is numerically below the bank's priority mask. Equal priority does not raise the line.
- R7: An access reaches only the bank selected by the processor index. The other banks keep their values.
- R8: A successful acknowledge sets the running priority to the pending priority. A spurious acknowledge leaves it unchanged.
- R9: The priority mask keeps the low 8 bits of a write and the binary point keeps the low 3 bits. Both read back zero-extended.
- R10: Writes to the acknowledge and running-priority offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Distributor-wide enable |
| reg_cpu | input | 3 | Bank select (processor index) |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (acknowledge side effect) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pend_vld | input | 8 | Pending interrupt valid, per processor |
| pend_id | input | 80 | Pending ID, 10 bits per processor |
| pend_pri | input | 64 | Pending priority, 8 bits per processor |
| pend_src | input | 24 | Source processor, 3 bits per processor |
| pend_act | input | 8 | Pending interrupt already active, per processor |
| irq | output | 8 | Interrupt request, per processor |

## Verification
The assertions assume that the arbiter inputs are stable around each clock edge. They also assume that reads and writes never share a cycle, and that the processor index always names an existing bank. The bench changes arbiter inputs and strobes only on falling edges. It issues one access at a time, each lasting one cycle, and it only ever addresses indices 0 to 7. The interrupt-line properties also assume that the running priority changes only through the acknowledge path. The bench never drives any other way of changing it.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;

   typedef enum logic [2:0] {
      RA_CTRL   = 3'd0,
      RA_PMASK  = 3'd1,
      RA_BINPT  = 3'd2,
      RA_ACK    = 3'd3,
      RA_RUNPRI = 3'd4
   } reg_addr_e;

   localparam int SPURIOUS_ID = 1023;
   localparam int SRC_LSB     = 10;
   localparam int SRC_W       = 3;
   localparam int EN_G0_BIT   = 0;
   localparam int EN_G1_BIT   = 1;

endpackage

// File: rtl/irq_cif_ack.sv
module irq_cif_ack
   import irq_cif_pkg::*;
#(
   parameter int ID_W   = 10,
   parameter int DATA_W = 32
) (
   input  logic              grant,
   input  logic [ID_W-1:0]   id,
   input  logic [SRC_W-1:0]  src,
   output logic [DATA_W-1:0] word
);

   initial begin
      assert (ID_W <= SRC_LSB) else $error("ID_W overlaps source field");
      assert (DATA_W >= SRC_LSB + SRC_W) else $error("DATA_W too narrow");
   end

   always_comb begin
      word = '0;
      if (grant) begin
         word[ID_W-1:0]          = id;
         word[SRC_LSB +: SRC_W]  = src;
      end else begin
         word = DATA_W'(SPURIOUS_ID);
      end
   end

endmodule

// File: rtl/irq_cif_bank.sv
module irq_cif_bank
   import irq_cif_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int PRI_W   = 8,
   parameter int BPR_W   = 3,
   parameter int BPR_RST = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glb_en,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack_take,
   input  logic              pend_vld,
   input  logic [PRI_W-1:0]  pend_pri,
   input  logic              pend_act,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [PRI_W-1:0]  pmr_q,
   output logic [BPR_W-1:0]  bpr_q,
   output logic [PRI_W-1:0]  rpr_q,
   output logic              cpu_en,
   output logic              irq
);

   localparam logic [PRI_W-1:0] PRI_IDLE = '1;

   initial begin
      assert (DATA_W >= 2) else $error("control word too narrow");
      assert (BPR_RST < (1 << BPR_W)) else $error("BPR_RST out of range");
   end

   logic want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pmr_q  <= PRI_IDLE;
         bpr_q  <= BPR_W'(BPR_RST);
      end else if (wr_en) begin
         case (reg_addr_e'(addr))
            RA_CTRL:  ctrl_q <= wdata;
            RA_PMASK: pmr_q  <= wdata[PRI_W-1:0];
            RA_BINPT: bpr_q  <= wdata[BPR_W-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rpr_q <= PRI_IDLE;
      else if (ack_take) rpr_q <= pend_pri;
   end

   assign cpu_en = ctrl_q[EN_G0_BIT] | ctrl_q[EN_G1_BIT];
   assign want   = glb_en & cpu_en & pend_vld & ~pend_act & (pend_pri < pmr_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= want;
         end
         assign irq = irq_q;

         AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(glb_en && pend_vld && !pend_act)); // R6
         AST_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ($past(pend_pri) < $past(pmr_q))); // R6
         AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[1:0] == 2'b00) |=> !irq); // R3
      end else begin : g_irq_comb
         assign irq = want;
      end
   endgenerate

   AST_CTRL_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_CTRL) |=> (ctrl_q == $past(wdata))); // R2
   AST_RPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_take |=> $stable(rpr_q)); // R8

endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
   import irq_cif_pkg::*;
#(
   parameter int NUM_CPU = 8,
   parameter int ID_W    = 10,
   parameter int PRI_W   = 8,
   parameter int BPR_W   = 3,
   parameter int BPR_RST = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     glb_en,
   input  logic [2:0]               reg_cpu,
   input  logic [2:0]               reg_addr,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   input  logic [NUM_CPU-1:0]       pend_vld,
   input  logic [NUM_CPU*ID_W-1:0]  pend_id,
   input  logic [NUM_CPU*PRI_W-1:0] pend_pri,
   input  logic [NUM_CPU*SRC_W-1:0] pend_src,
   input  logic [NUM_CPU-1:0]       pend_act,
   output logic [NUM_CPU-1:0]       irq
);

   localparam int DATA_W = 32;

   initial begin
      assert (NUM_CPU >= 1 && NUM_CPU <= (1 << SRC_W)) else $error("NUM_CPU out of range");
      assert (PRI_W <= DATA_W && BPR_W <= DATA_W) else $error("field wider than data");
   end

   logic [DATA_W-1:0] ctrl_a [NUM_CPU];
   logic [PRI_W-1:0]  pmr_a  [NUM_CPU];
   logic [BPR_W-1:0]  bpr_a  [NUM_CPU];
   logic [PRI_W-1:0]  rpr_a  [NUM_CPU];
   logic [NUM_CPU-1:0] en_a;
   logic [NUM_CPU-1:0] wr_sel;
   logic [NUM_CPU-1:0] take_sel;

   logic              sel_ok;
   logic              sel_en, sel_vld, grant, ack_rd;
   logic [ID_W-1:0]   sel_id;
   logic [SRC_W-1:0]  sel_src;
   logic [DATA_W-1:0] ack_word;

   assign sel_ok = 32'(reg_cpu) < NUM_CPU;

   always_comb begin
      sel_en  = 1'b0;
      sel_vld = 1'b0;
      sel_id  = '0;
      sel_src = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (sel_ok && 32'(reg_cpu) == c) begin
            sel_en  = en_a[c];
            sel_vld = pend_vld[c];
            sel_id  = pend_id[c*ID_W +: ID_W];
            sel_src = pend_src[c*SRC_W +: SRC_W];
         end
      end
   end

   assign grant  = glb_en & sel_en & sel_vld;
   assign ack_rd = reg_rd & (reg_addr == RA_ACK);

   irq_cif_ack #(.ID_W(ID_W), .DATA_W(DATA_W)) i_ack (
      .grant (grant),
      .id    (sel_id),
      .src   (sel_src),
      .word  (ack_word)
   );

   generate
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
         assign wr_sel[c]   = reg_wr & sel_ok & (32'(reg_cpu) == c);
         assign take_sel[c] = ack_rd & grant & sel_ok & (32'(reg_cpu) == c);

         irq_cif_bank #(
            .DATA_W (DATA_W), .PRI_W (PRI_W), .BPR_W (BPR_W),
            .BPR_RST(BPR_RST), .IRQ_REG(IRQ_REG)
         ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .glb_en   (glb_en),
            .wr_en    (wr_sel[c]),
            .addr     (reg_addr),
            .wdata    (reg_wdata),
            .ack_take (take_sel[c]),
            .pend_vld (pend_vld[c]),
            .pend_pri (pend_pri[c*PRI_W +: PRI_W]),
            .pend_act (pend_act[c]),
            .ctrl_q   (ctrl_a[c]),
            .pmr_q    (pmr_a[c]),
            .bpr_q    (bpr_a[c]),
            .rpr_q    (rpr_a[c]),
            .cpu_en   (en_a[c]),
            .irq      (irq[c])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (sel_ok && 32'(reg_cpu) == c) begin
            case (reg_addr_e'(reg_addr))
               RA_CTRL:   reg_rdata = ctrl_a[c];
               RA_PMASK:  reg_rdata = DATA_W'(pmr_a[c]);
               RA_BINPT:  reg_rdata = DATA_W'(bpr_a[c]);
               RA_ACK:    reg_rdata = ack_word;
               RA_RUNPRI: reg_rdata = DATA_W'(rpr_a[c]);
               default:   reg_rdata = '0;
            endcase
         end
      end
   end

   AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel)); // R7
   AST_ONE_BANK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_sel)); // R7
   AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && (!glb_en || !sel_vld)) |-> (reg_rdata == 32'd1023)); // R5
   AST_ACK_SRC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && reg_rdata != 32'd1023) |-> (reg_rdata[31:13] == '0)); // R4

endmodule

// File: tb/test_irq_cpu_iface.sv
module test_irq_cpu_iface;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glb_en = 1'b0;
   logic [2:0]  reg_cpu = '0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NC-1:0]    pend_vld = '0;
   logic [NC*10-1:0] pend_id = '0;
   logic [NC*8-1:0]  pend_pri = '0;
   logic [NC*3-1:0]  pend_src = '0;
   logic [NC-1:0]    pend_act = '0;
   logic [NC-1:0]    irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_cpu_iface i_irq_cpu_iface (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
      .reg_cpu(reg_cpu), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pend_vld(pend_vld), .pend_id(pend_id), .pend_pri(pend_pri),
      .pend_src(pend_src), .pend_act(pend_act), .irq(irq)
   );

   // {expected enable, control word}
   localparam logic [32:0] CTRL_TBL [9] = '{
      {1'b0, 32'h0000_0000}, {1'b1, 32'h0000_0001}, {1'b1, 32'h0000_0002},
      {1'b1, 32'h0000_0003}, {1'b0, 32'h0000_0008}, {1'b0, 32'h0000_0004},
      {1'b0, 32'hFFFF_FFFC}, {1'b0, 32'h8000_0000}, {1'b1, 32'h0000_000F}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int cpu, input int addr, input logic [31:0] d);
      @(negedge clk);
      reg_cpu = 3'(cpu); reg_addr = 3'(addr); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int cpu, input int addr, output logic [31:0] d);
      @(negedge clk);
      reg_cpu = 3'(cpu); reg_addr = 3'(addr); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] ack_ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 irq", 32'(irq), 32'h0);
      foreach (CTRL_TBL[k]) begin end
      for (int c = 0; c < NC; c += 7) begin
         rd(c, 0, v); check("R1 ctrl", v, 32'h0);
         rd(c, 1, v); check("R1 pmask", v, 32'hFF);
         rd(c, 4, v); check("R1 runpri", v, 32'hFF);
         rd(c, 2, v); check("R1 binpt", v, 32'd2);
      end

      // pending setup on CPU0: id 0x2A, src 5, pri 0x40
      @(negedge clk);
      glb_en = 1'b1;
      pend_vld[0] = 1'b1;
      pend_id[9:0] = 10'h2A;
      pend_src[2:0] = 3'd5;
      pend_pri[7:0] = 8'h40;
      ack_ok = (32'd5 << 10) | 32'h2A;

      // R2 R3 R4 table walk
      for (int k = 0; k < 9; k++) begin
         wr(0, 0, CTRL_TBL[k][31:0]);
         settle();
         check("R3 irq", 32'(irq[0]), 32'(CTRL_TBL[k][32]));
         rd(0, 0, v); check("R2 ctrl readback", v, CTRL_TBL[k][31:0]);
         rd(0, 3, v); check("R3/R4 ack", v, CTRL_TBL[k][32] ? ack_ok : 32'd1023);
      end

      // R6 mask comparison and active flag
      wr(0, 0, 32'h1);
      wr(0, 1, 32'h40);
      settle(); check("R6 equal prio", 32'(irq[0]), 32'h0);
      wr(0, 1, 32'h41);
      settle(); check("R6 below mask", 32'(irq[0]), 32'h1);
      @(negedge clk); pend_act[0] = 1'b1;
      settle(); check("R6 active", 32'(irq[0]), 32'h0);
      @(negedge clk); pend_act[0] = 1'b0; glb_en = 1'b0;
      settle(); check("R6 global off", 32'(irq[0]), 32'h0);
      rd(0, 3, v); check("R5 global off ack", v, 32'd1023);
      @(negedge clk); glb_en = 1'b1;
      settle(); check("R6 back on", 32'(irq[0]), 32'h1);

      // R5 nothing pending
      @(negedge clk); pend_vld[0] = 1'b0;
      rd(0, 3, v); check("R5 none pending", v, 32'd1023);
      settle(); check("R6 none pending irq", 32'(irq[0]), 32'h0);
      @(negedge clk); pend_vld[0] = 1'b1;

      // R8 running priority
      @(negedge clk); pend_pri[7:0] = 8'h30;
      rd(0, 3, v); check("R4 ack", v, ack_ok);
      rd(0, 4, v); check("R8 runpri loaded", v, 32'h30);
      @(negedge clk); pend_pri[7:0] = 8'h10;
      wr(0, 0, 32'h8);
      rd(0, 3, v); check("R5 disabled ack", v, 32'd1023);
      rd(0, 4, v); check("R8 runpri kept", v, 32'h30);

      // R7 banking
      wr(3, 1, 32'h22);
      rd(3, 1, v); check("R7 cpu3 pmask", v, 32'h22);
      rd(4, 1, v); check("R7 cpu4 pmask", v, 32'hFF);
      rd(0, 0, v); check("R7 cpu0 ctrl", v, 32'h8);
      settle(); check("R7 other irq", 32'(irq[7:1]), 32'h0);

      // R9 field widths
      wr(2, 1, 32'h1234);
      rd(2, 1, v); check("R9 pmask width", v, 32'h34);
      wr(2, 2, 32'hFF);
      rd(2, 2, v); check("R9 binpt width", v, 32'h7);

      // R10 read-only offsets
      wr(0, 4, 32'h05);
      wr(0, 3, 32'h3);
      rd(0, 4, v); check("R10 runpri unchanged", v, 32'h30);
      rd(0, 0, v); check("R10 ctrl unchanged", v, 32'h8);

      done = 1'b1;
      finish_run();
   end

endmodule